// File: doc/BRIEF.md
# Shared-Pin Parallel I/O Port

This block is a parameterised general-purpose I/O port, 16 pins wide by default. Every pin is shared between the port logic and an on-chip peripheral. Software controls the port through three registers on a simple bus:
- a direction register, where a 1 makes the pin an input;
- an output latch;
- a port register, which returns the synchronised pin levels when read and loads the latch when written.

Ownership is decided per pin. When the peripheral is enabled and also asserts its output enable on a pin, the peripheral's data and enable reach the pad, and the port driver for that pin is taken out of the path. The pin can still be read. When the port drives a pin as an output, the peripheral's input line for that pin is held at 0. This prevents the port's own output from looping back into the peripheral.

Two parameter masks describe the silicon. One marks pins that are not implemented: these read as 0 everywhere, ignore writes and are never driven. The other marks input-only pins: their direction bit is always 1, and nothing can drive them.

Top module: `shared_pin_port`

## Requirements
- R1: After reset the direction register reads 1 on every implemented bit, the latch reads 0, and pin_oe is 0 on all bits.
- R2: A direction bit of 0 on an implemented pin that the peripheral does not own drives pin_oe high for that bit and puts the latch bit on pin_out.
- R3: Select value 2 addresses the latch. A write with this select loads it, and a read with this select returns the latch contents.
- R4: A write with select value 1 (port) loads the latch. A read with select value 1 returns pin_in, delayed by two rising clock edges.
- R5: When per_en and per_oe are both 1 on a pin, that pin has pin_oe=1 and pin_out=per_out, whatever the direction and latch bits hold.
- R6: When per_en is 1 but per_oe is 0 on a pin, the direction and latch bits control that pin, exactly as when the peripheral is disabled.
- R7: On a pin that the port drives as an output and the peripheral does not own, per_in is 0.
- R8: A pin outside IMPL_MASK reads 0 in the direction, latch and port registers, ignores writes, and never has pin_oe set.
- R9: A pin in INONLY_MASK reads 1 in the direction register regardless of writes, and never has pin_oe set, even when the peripheral requests it.
- R10: Select value 0 addresses the direction register. Select value 3 reads as zero.
- R11: On a pin that the port does not drive, per_in follows pin_in with the same two-edge delay as the port register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register select: 0 direction, 1 port, 2 latch, 3 none |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Combinational read data for bus_sel |
| pin_in | input | W | Pad input levels |
| pin_out | output | W | Pad output data |
| pin_oe | output | W | Pad output enable |
| per_en | input | W | Peripheral enable, one bit per pin |
| per_oe | input | W | Peripheral output enable |
| per_out | input | W | Peripheral output data |
| per_in | output | W | Synchronised pin level to the peripheral, gated |

## Verification
The hardest case to reach from the ports is loop-through gating. It needs a pin that the port drives as an output while the peripheral is enabled elsewhere, and a high level that has already passed through the synchronizer. To build it, the stimulus applies pin_in, waits two edges, then sets a mixed direction pattern together with partial peripheral ownership. This puts pins that are port-driven, peripheral-owned and plain inputs side by side in one per_in vector. The masked pins are exercised with the peripheral requesting ownership of them, so that the masks are shown to override the ownership logic.

// File: rtl/shared_pin_port.sv
module shared_pin_port #(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL_MASK = '1,
  parameter logic [W-1:0] INONLY_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_sel,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic [W-1:0] per_en,
  input  logic [W-1:0] per_oe,
  input  logic [W-1:0] per_out,
  output logic [W-1:0] per_in
);
  localparam logic [W-1:0] CAN_DRIVE = IMPL_MASK & ~INONLY_MASK;

  logic [W-1:0] dir_q, latch_q, sync1_q, sync2_q;
  logic [W-1:0] own, port_drv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= IMPL_MASK;
      latch_q <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in & IMPL_MASK;
      sync2_q <= sync1_q;
      if (bus_we) begin
        case (bus_sel)
          2'd0: dir_q <= (bus_wdata | INONLY_MASK) & IMPL_MASK;
          2'd1, 2'd2: latch_q <= bus_wdata & IMPL_MASK;
          default: ;
        endcase
      end
    end
  end

  assign own      = per_en & per_oe & CAN_DRIVE;
  assign port_drv = ~dir_q & ~own & CAN_DRIVE;
  assign pin_oe   = own | port_drv;
  assign pin_out  = ((own & per_out) | (~own & latch_q)) & IMPL_MASK;
  assign per_in   = sync2_q & ~port_drv;

  always_comb begin
    case (bus_sel)
      2'd0:    bus_rdata = dir_q;
      2'd1:    bus_rdata = sync2_q;
      2'd2:    bus_rdata = latch_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/shared_pin_port_chk.sv
module shared_pin_port_chk #(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL_MASK = '1,
  parameter logic [W-1:0] INONLY_MASK = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   bus_sel,
  input logic         bus_we,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] per_en,
  input logic [W-1:0] per_oe,
  input logic [W-1:0] per_out,
  input logic [W-1:0] per_in,
  input logic [W-1:0] latch_q
);
  logic [W-1:0] req;
  assign req = per_en & per_oe & IMPL_MASK & ~INONLY_MASK;

  // R5
  peripheral_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & req) == req) && ((pin_out & req) == (per_out & req)));

  // R8
  unimpl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe | pin_out | per_in) & ~IMPL_MASK) == '0);

  // R9
  inonly_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & INONLY_MASK) == '0);

  // R7
  no_loopthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_in & pin_oe & ~req) == '0);

  // R3
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_sel == 2'd1 || bus_sel == 2'd2)) |=>
      latch_q == ($past(bus_wdata) & IMPL_MASK));
endmodule

bind shared_pin_port shared_pin_port_chk #(
  .W(W), .IMPL_MASK(IMPL_MASK), .INONLY_MASK(INONLY_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .per_en(per_en), .per_oe(per_oe), .per_out(per_out),
  .per_in(per_in), .latch_q(latch_q)
);

// File: tb/shared_pin_port_test.sv
module shared_pin_port_test;
  localparam logic [15:0] IMPL = 16'hBFFF;
  localparam logic [15:0] INONLY = 16'h2000;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [15:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic [15:0] per_en = '0, per_oe = '0, per_out = '0, per_in;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shared_pin_port #(.W(16), .IMPL_MASK(IMPL), .INONLY_MASK(INONLY)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .per_en(per_en), .per_oe(per_oe),
    .per_out(per_out), .per_in(per_in));

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [15:0] d);
    @(negedge clk);
    bus_sel = sel;
    #1 d = bus_rdata;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(2'd0, d); check("R1 dir", d, IMPL);
    rd(2'd2, d); check("R1 latch", d, 16'h0000);
    check("R1 oe", pin_oe, 16'h0000);
  endtask

  task automatic t_dir_latch;
    logic [15:0] d;
    wr(2'd0, 16'h0000);
    rd(2'd0, d); check("R10 dir read", d, 16'h2000);
    check("R2 oe", pin_oe, 16'h9FFF);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d); check("R3 latch read", d, 16'hBFFF);
    check("R2 out", pin_out, 16'hBFFF);
    rd(2'd3, d); check("R10 sel3", d, 16'h0000);
  endtask

  task automatic t_port;
    logic [15:0] d;
    wr(2'd1, 16'h1234);
    rd(2'd2, d); check("R4 port write", d, 16'h1234);
    wr(2'd0, 16'hFFFF);
    @(negedge clk); pin_in = 16'hFFFF; bus_sel = 2'd1;
    @(posedge clk); #1 check("R4 one edge", bus_rdata, 16'h0000);
    check("R11 one edge", per_in, 16'h0000);
    @(posedge clk); #1 check("R4 two edges", bus_rdata, 16'hBFFF);
    check("R11 two edges", per_in, 16'hBFFF);
  endtask

  task automatic t_periph;
    logic [15:0] d;
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h00F0);
    @(negedge clk);
    per_en = 16'h00FF; per_oe = 16'h000F; per_out = 16'h0005;
    #1 check("R5 oe", pin_oe, 16'h9FFF);
    check("R6 out", pin_out, 16'h00F5);
    wr(2'd0, 16'hFFFF);
    #1 check("R5 oe dir in", pin_oe, 16'h000F);
    check("R5 out dir in", pin_out, 16'h00F5);
    rd(2'd1, d); check("R5 pin readable", d, 16'hBFFF);
  endtask

  task automatic t_loop;
    wr(2'd0, 16'hFF00);
    @(negedge clk); per_en = 16'h000F; per_oe = 16'h000F;
    #1 check("R7 gate", per_in, 16'hBF0F);
    check("R7 oe", pin_oe, 16'h00FF);
  endtask

  task automatic t_masks;
    logic [15:0] d;
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'hFFFF);
    @(negedge clk); per_en = 16'h6000; per_oe = 16'h6000; per_out = 16'hFFFF;
    rd(2'd0, d); check("R9 dir stays 1", d, 16'h2000);
    rd(2'd2, d); check("R8 latch masked", d, 16'hBFFF);
    rd(2'd1, d); check("R8 port masked", d, 16'hBFFF);
    check("R8 R9 oe", pin_oe, 16'h9FFF);
    check("R8 out", pin_out & ~IMPL, 16'h0000);
  endtask

  initial begin
    settle(3);
    rst_n = 1'b1;
    t_reset;
    t_dir_latch;
    t_port;
    t_periph;
    t_loop;
    t_masks;
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule